// File: doc/BRIEF.md
# Prescaled 8-bit Timer with Compare Waveform Output

This block is an up-counting timer with a selectable clock divider, one compare register and one waveform pin. A divider choice turns the system clock into timer ticks. The counter advances only on a tick. On every tick the counter value is compared with the active compare value. Depending on the waveform mode, the counter either runs freely through its full range, restarts after a compare match, or produces a single-slope pulse-width-modulated signal.

Control comes in as register-style levels. These select the waveform mode, the output action on a compare match, the divider choice and the compare value. A write strobe loads the compare value. Two flags report compare matches and counter wrap-around. Each flag stays set until its clear strobe is pulsed. In PWM mode a new compare value is parked in a shadow register and only takes over when the counter wraps. This keeps a write from producing a glitched pulse within the current period.

Top module: `wavetimer8`

## Requirements
- R1: While `rst` is high at a clock edge, `count`, `wave_out`, `cmp_flag`, `ovf_flag`, the active and shadow compare values and the divider phase all become 0.
- R2: `clk_sel` codes 1, 2, 3, 4 and 5 select a divide ratio N of 1, 8, 64, 256 and 1024. A tick occurs on the clock edges where the number of edges since reset was released, taken modulo N, equals N-1; the first edge after reset is number 0. Codes 0, 6 and 7 give no ticks. `count`, both flags and `wave_out` change only on ticks, apart from the flag clears (R12) and reset.
- R3: In waveform modes 0 and 1 (normal), `count` rises by one per tick and wraps from 0xFF to 0x00. In every mode, `ovf_flag` sets on the tick where `count` goes from 0xFF to 0x00.
- R4: In waveform mode 2 (clear on match), a tick on which `count` equals the active compare value sets `count` to 0x00. In every mode, a tick with such a match sets `cmp_flag`.
- R5: In mode 2, if the compare value is written below the present count, there is no match until the counter has run up to 0xFF and wrapped to 0x00.
- R6: In mode 2 with `out_mode` 1, `wave_out` toggles on each match tick. At divide ratio 1 the toggles are 1 + compare value clock cycles apart, so a compare value of 0 toggles it on every tick.
- R7: In mode 3 (fast PWM) with `out_mode` 2, `wave_out` is set on the tick where `count` wraps from 0xFF to 0x00. Otherwise it is cleared on a match tick. The wrap takes priority, so a compare value of 0xFF keeps the output high.
- R8: In mode 3 with `out_mode` 3, `wave_out` is cleared on the wrap tick and otherwise set on a match tick, with the wrap taking priority.
- R9: In mode 3, `cmp_wr` only loads the shadow value. The active compare value takes the shadow value on the tick where `count` wraps from 0xFF to 0x00.
- R10: In modes 0 to 2, `cmp_wr` loads the active compare value at the same clock edge, whether or not a tick occurs there.
- R11: `out_mode` 0 holds `wave_out` at its last value in every waveform mode. `out_mode` 1 also holds it in mode 3.
- R12: `cmp_flag_clr` or `ovf_flag_clr` clears its flag at the next clock edge. If the flag is set on that same edge, the set wins and the flag stays 1.
- R13: In modes 0 to 2, a match tick clears `wave_out` when `out_mode` is 2 and sets it when `out_mode` is 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_sel | input | 3 | Divider choice: 0 stop, 1..5 divide by 1/8/64/256/1024, 6..7 stop |
| wave_mode | input | 2 | 0/1 normal, 2 clear on match, 3 fast PWM |
| out_mode | input | 2 | Output action on match: 0 hold, 1 toggle, 2 clear / non-inverting, 3 set / inverting |
| cmp_wr | input | 1 | Compare value write strobe |
| cmp_wdata | input | 8 | Compare value to write |
| cmp_flag_clr | input | 1 | Clears the compare flag |
| ovf_flag_clr | input | 1 | Clears the overflow flag |
| count | output | 8 | Current counter value |
| wave_out | output | 1 | Waveform output |
| cmp_flag | output | 1 | Compare match flag |
| ovf_flag | output | 1 | Counter wrap flag |

## Verification
The assertions check these properties on every cycle:
- A stopped divider freezes the counter.
- A hold output mode freezes the pin.
- Every wrap from 0xFF to 0x00 leaves the overflow flag set.
- A jump to zero from any value other than 0xFF happens only in clear-on-match mode, and it raises the compare flag.
- In PWM mode the pin takes the level required by the polarity at each wrap.
- A flag clear with no wrap leaves the overflow flag low.

Only the bench scenarios can show the other behaviours:
- the tick spacing for each divider choice;
- the toggle period in clear-on-match mode;
- the missed compare after a value is written below the count;
- the PWM duty cycle and the delay of a new PWM compare value until the next wrap, compared with the immediate update in the other modes;
- a set and a clear of a flag landing on the same edge.

// File: rtl/wt_pkg.sv
package wt_pkg;

   // Waveform modes; code 1 is a second encoding of free-running operation.
   typedef enum logic [1:0] {
      WM_NORMAL     = 2'd0,
      WM_NORMAL_ALT = 2'd1,
      WM_CTC        = 2'd2,
      WM_FPWM       = 2'd3
   } wave_mode_e;

   // Output action on a compare match (polarity selector in PWM mode).
   typedef enum logic [1:0] {
      OM_HOLD   = 2'd0,
      OM_TOGGLE = 2'd1,
      OM_LOW    = 2'd2,
      OM_HIGH   = 2'd3
   } out_mode_e;

   // Divider taps: log2 of each selectable ratio, in selector order 1..5.
   localparam int unsigned NUM_TAPS = 5;
   localparam int unsigned TAP_SHIFT [NUM_TAPS] = '{0, 3, 6, 8, 10};

   // Per-tick event bundle handed from the counting logic to the output stage.
   typedef struct packed {
      logic tick;
      logic at_max;
      logic match;
   } tmr_evt_t;

endpackage

// File: rtl/wt_prescaler.sv
module wt_prescaler
   import wt_pkg::*;
#(
   parameter int unsigned DIV_W = 10,
   parameter int unsigned SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);

   localparam int unsigned MAX_SHIFT = TAP_SHIFT[NUM_TAPS-1];

   if (DIV_W < MAX_SHIFT) begin : g_chk_div
      $error("wt_prescaler: DIV_W too narrow for the largest tap");
   end
   if ((1 << SEL_W) <= NUM_TAPS) begin : g_chk_sel
      $error("wt_prescaler: SEL_W cannot encode every tap");
   end

   logic [DIV_W-1:0]    div_q;
   logic [NUM_TAPS-1:0] tap_hit;

   // Free-running phase counter; its length is a multiple of every ratio.
   always_ff @(posedge clk) begin
      if (rst) div_q <= '0;
      else     div_q <= div_q + 1'b1;
   end

   for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
      if (TAP_SHIFT[i] == 0) begin : g_direct
         assign tap_hit[i] = 1'b1;
      end else begin : g_mask
         assign tap_hit[i] = &div_q[TAP_SHIFT[i]-1:0];
      end
   end

   always_comb begin
      tick = 1'b0;
      for (int k = 0; k < NUM_TAPS; k++) begin
         if (sel == SEL_W'(k + 1)) tick = tap_hit[k];
      end
   end

endmodule

// File: rtl/wt_counter.sv
module wt_counter #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick,
   input  logic             clear_on_tick,
   output logic [CNT_W-1:0] cnt,
   output logic             at_max
);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt <= '0;
      end else if (tick) begin
         if (clear_on_tick) cnt <= '0;
         else               cnt <= cnt + 1'b1;
      end
   end

   assign at_max = &cnt;

endmodule

// File: rtl/wt_compare.sv
module wt_compare #(
   parameter int unsigned CNT_W    = 8,
   parameter bit          BUFFERED = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             pwm_mode,
   input  logic             reload,
   input  logic [CNT_W-1:0] cnt,
   output logic             match
);

   logic [CNT_W-1:0] active_q;

   if (BUFFERED) begin : g_buffered
      logic [CNT_W-1:0] shadow_q;

      always_ff @(posedge clk) begin
         if (rst)        shadow_q <= '0;
         else if (wr_en) shadow_q <= wr_data;
      end

      // Direct load outside PWM; shadow transfer at the wrap inside PWM.
      always_ff @(posedge clk) begin
         if (rst)                    active_q <= '0;
         else if (!pwm_mode && wr_en) active_q <= wr_data;
         else if (pwm_mode && reload) active_q <= shadow_q;
      end
   end else begin : g_direct
      logic unused_ok;
      assign unused_ok = pwm_mode ^ reload;

      always_ff @(posedge clk) begin
         if (rst)        active_q <= '0;
         else if (wr_en) active_q <= wr_data;
      end
   end

   assign match = (cnt == active_q);

endmodule

// File: rtl/wt_waveout.sv
module wt_waveout
   import wt_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  tmr_evt_t   evt,
   input  logic       pwm_mode,
   input  logic [1:0] omode,
   output logic       wave
);

   out_mode_e om;
   logic      wave_d;

   assign om = out_mode_e'(omode);

   always_comb begin
      wave_d = wave;
      if (evt.tick) begin
         unique case (om)
            OM_HOLD: wave_d = wave;
            OM_TOGGLE: begin
               if (!pwm_mode && evt.match) wave_d = ~wave;
            end
            OM_LOW: begin
               if (pwm_mode) begin
                  if (evt.at_max)     wave_d = 1'b1;
                  else if (evt.match) wave_d = 1'b0;
               end else if (evt.match) begin
                  wave_d = 1'b0;
               end
            end
            OM_HIGH: begin
               if (pwm_mode) begin
                  if (evt.at_max)     wave_d = 1'b0;
                  else if (evt.match) wave_d = 1'b1;
               end else if (evt.match) begin
                  wave_d = 1'b1;
               end
            end
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) wave <= 1'b0;
      else     wave <= wave_d;
   end

endmodule

// File: rtl/wt_flag.sv
module wt_flag (
   input  logic clk,
   input  logic rst,
   input  logic set,
   input  logic clr,
   output logic q
);

   always_ff @(posedge clk) begin
      if (rst)      q <= 1'b0;
      else if (set) q <= 1'b1;
      else if (clr) q <= 1'b0;
   end

endmodule

// File: rtl/wavetimer8.sv
module wavetimer8
   import wt_pkg::*;
#(
   parameter int unsigned CNT_W        = 8,
   parameter int unsigned DIV_W        = 10,
   parameter int unsigned SEL_W        = 3,
   parameter bit          PWM_BUFFERED = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [SEL_W-1:0] clk_sel,
   input  logic [1:0]       wave_mode,
   input  logic [1:0]       out_mode,
   input  logic             cmp_wr,
   input  logic [CNT_W-1:0] cmp_wdata,
   input  logic             cmp_flag_clr,
   input  logic             ovf_flag_clr,
   output logic [CNT_W-1:0] count,
   output logic             wave_out,
   output logic             cmp_flag,
   output logic             ovf_flag
);

   if (CNT_W < 2) begin : g_chk_width
      $error("wavetimer8: CNT_W must be at least 2");
   end

   wave_mode_e wm;
   logic       pwm_mode;
   logic       ctc_mode;
   tmr_evt_t   evt;

   assign wm       = wave_mode_e'(wave_mode);
   assign pwm_mode = (wm == WM_FPWM);
   assign ctc_mode = (wm == WM_CTC);

   wt_prescaler #(
      .DIV_W (DIV_W),
      .SEL_W (SEL_W)
   ) u_presc (
      .clk  (clk),
      .rst  (rst),
      .sel  (clk_sel),
      .tick (evt.tick)
   );

   wt_counter #(
      .CNT_W (CNT_W)
   ) u_cnt (
      .clk           (clk),
      .rst           (rst),
      .tick          (evt.tick),
      .clear_on_tick (ctc_mode & evt.match),
      .cnt           (count),
      .at_max        (evt.at_max)
   );

   wt_compare #(
      .CNT_W    (CNT_W),
      .BUFFERED (PWM_BUFFERED)
   ) u_cmp (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (cmp_wr),
      .wr_data  (cmp_wdata),
      .pwm_mode (pwm_mode),
      .reload   (evt.tick & evt.at_max),
      .cnt      (count),
      .match    (evt.match)
   );

   wt_waveout u_wave (
      .clk      (clk),
      .rst      (rst),
      .evt      (evt),
      .pwm_mode (pwm_mode),
      .omode    (out_mode),
      .wave     (wave_out)
   );

   wt_flag u_cmp_flag (
      .clk (clk),
      .rst (rst),
      .set (evt.tick & evt.match),
      .clr (cmp_flag_clr),
      .q   (cmp_flag)
   );

   wt_flag u_ovf_flag (
      .clk (clk),
      .rst (rst),
      .set (evt.tick & evt.at_max),
      .clr (ovf_flag_clr),
      .q   (ovf_flag)
   );

endmodule

// File: rtl/wt_checker.sv
module wt_checker #(
   parameter int unsigned CNT_W = 8,
   parameter int unsigned SEL_W = 3
) (
   input logic             clk,
   input logic             rst,
   input logic [SEL_W-1:0] clk_sel,
   input logic [1:0]       wave_mode,
   input logic [1:0]       out_mode,
   input logic             ovf_flag_clr,
   input logic [CNT_W-1:0] count,
   input logic             wave_out,
   input logic             cmp_flag,
   input logic             ovf_flag
);

   localparam logic [CNT_W-1:0] CNT_TOP = '1;

   assert_stopped_R2: assert property (@(posedge clk) disable iff (rst)
      (clk_sel == '0) |=> $stable(count));

   assert_wrap_flag_R3: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(count) == CNT_TOP && count == '0) |-> ovf_flag);

   assert_ctc_restart_R4: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(count) != CNT_TOP && $past(count) != '0 && count == '0)
      |-> ($past(wave_mode) == 2'd2 && cmp_flag));

   assert_pwm_noninv_R7: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(wave_mode) == 2'd3 && $past(out_mode) == 2'd2 &&
       $past(count) == CNT_TOP && count == '0) |-> wave_out);

   assert_pwm_inv_R8: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(wave_mode) == 2'd3 && $past(out_mode) == 2'd3 &&
       $past(count) == CNT_TOP && count == '0) |-> !wave_out);

   assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
      (out_mode == 2'd0) |=> $stable(wave_out));

   assert_ovf_clear_R12: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(ovf_flag_clr) && $past(count) == count) |-> !ovf_flag);

endmodule

bind wavetimer8 wt_checker #(
   .CNT_W (CNT_W),
   .SEL_W (SEL_W)
) u_wt_checker (
   .clk          (clk),
   .rst          (rst),
   .clk_sel      (clk_sel),
   .wave_mode    (wave_mode),
   .out_mode     (out_mode),
   .ovf_flag_clr (ovf_flag_clr),
   .count        (count),
   .wave_out     (wave_out),
   .cmp_flag     (cmp_flag),
   .ovf_flag     (ovf_flag)
);

// File: tb/wavetimer8_bench.sv
`timescale 1ns/1ps
module wavetimer8_bench;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [2:0] clk_sel = '0;
   logic [1:0] wave_mode = '0;
   logic [1:0] out_mode = '0;
   logic       cmp_wr = 1'b0;
   logic [7:0] cmp_wdata = '0;
   logic       cmp_flag_clr = 1'b0;
   logic       ovf_flag_clr = 1'b0;
   logic [7:0] count;
   logic       wave_out;
   logic       cmp_flag;
   logic       ovf_flag;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   // Reference state
   int m_div = 0, m_cnt = 0, m_ocr = 0, m_buf = 0, m_out = 0, m_cf = 0, m_of = 0;

   always #2.5 clk = ~clk;

   wavetimer8 u_wavetimer8 (
      .clk          (clk),
      .rst          (rst),
      .clk_sel      (clk_sel),
      .wave_mode    (wave_mode),
      .out_mode     (out_mode),
      .cmp_wr       (cmp_wr),
      .cmp_wdata    (cmp_wdata),
      .cmp_flag_clr (cmp_flag_clr),
      .ovf_flag_clr (ovf_flag_clr),
      .count        (count),
      .wave_out     (wave_out),
      .cmp_flag     (cmp_flag),
      .ovf_flag     (ovf_flag)
   );

   task automatic chk(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   function automatic int ratio(int sel);
      case (sel)
         1: return 1;
         2: return 8;
         3: return 64;
         4: return 256;
         5: return 1024;
         default: return 0;
      endcase
   endfunction

   // Behavioural reference, advanced on each rising edge
   always @(posedge clk) begin
      int n;
      bit tk, mt, mx;
      cyc++;
      if (rst) begin
         m_div = 0; m_cnt = 0; m_ocr = 0; m_buf = 0; m_out = 0; m_cf = 0; m_of = 0;
      end else begin
         n  = ratio(int'(clk_sel));
         tk = (n != 0) && ((m_div % n) == n - 1);
         mt = (m_cnt == m_ocr);
         mx = (m_cnt == 255);
         if (tk) begin
            if (wave_mode == 2'd3) begin
               if (out_mode == 2'd2) begin
                  if (mx) m_out = 1; else if (mt) m_out = 0;
               end else if (out_mode == 2'd3) begin
                  if (mx) m_out = 0; else if (mt) m_out = 1;
               end
            end else if (mt) begin
               case (out_mode)
                  2'd1: m_out = 1 - m_out;
                  2'd2: m_out = 0;
                  2'd3: m_out = 1;
                  default: ;
               endcase
            end
         end
         if (tk && mt) m_cf = 1; else if (cmp_flag_clr) m_cf = 0;
         if (tk && mx) m_of = 1; else if (ovf_flag_clr) m_of = 0;
         if (wave_mode != 2'd3 && cmp_wr) m_ocr = int'(cmp_wdata);
         else if (wave_mode == 2'd3 && tk && mx) m_ocr = m_buf;
         if (cmp_wr) m_buf = int'(cmp_wdata);
         if (tk) m_cnt = (wave_mode == 2'd2 && mt) ? 0 : (m_cnt + 1) % 256;
         m_div = (m_div + 1) % 1024;
      end
   end

   // Per-cycle comparison away from the active edge
   always @(negedge clk) begin
      if (cyc > 0) begin
         chk(int'(count) == m_cnt, "R3 count", int'(count), m_cnt);
         chk(int'(wave_out) == m_out, "R7 wave_out", int'(wave_out), m_out);
         chk(int'(cmp_flag) == m_cf, "R4 cmp_flag", int'(cmp_flag), m_cf);
         chk(int'(ovf_flag) == m_of, "R12 ovf_flag", int'(ovf_flag), m_of);
      end
   end

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_count(int v);
      int guard = 0;
      while (int'(count) != v && guard < 5000) begin
         @(negedge clk);
         guard++;
      end
      chk(guard < 5000, "wait", int'(count), v);
   endtask

   task automatic write_cmp(int v);
      cmp_wr = 1'b1;
      cmp_wdata = 8'(v);
      @(negedge clk);
      cmp_wr = 1'b0;
   endtask

   task automatic measure_toggles(int gap, string req);
      int stamps[$];
      logic prev;
      int guard = 0;
      prev = wave_out;
      while (stamps.size() < 4 && guard < 2000) begin
         @(negedge clk);
         guard++;
         if (wave_out !== prev) begin
            stamps.push_back(cyc);
            prev = wave_out;
         end
      end
      chk(stamps.size() == 4, req, stamps.size(), 4);
      for (int i = 1; i < stamps.size(); i++)
         chk(stamps[i] - stamps[i-1] == gap, req, stamps[i] - stamps[i-1], gap);
   endtask

   task automatic high_cycles(int exp, string req);
      int hi = 0;
      for (int i = 0; i < 256; i++) begin
         if (wave_out) hi++;
         @(negedge clk);
      end
      chk(hi == exp, req, hi, exp);
   endtask

   initial begin
      int v;
      int seen_max;
      int changes;
      logic held;

      step(3);
      // R1: reset state
      chk(count == 8'd0 && !wave_out && !cmp_flag && !ovf_flag, "R1",
          int'({count, wave_out, cmp_flag, ovf_flag}), 0);
      rst = 1'b0;

      // R3: free-running count and wrap flag
      clk_sel = 3'd1;
      wait_count(255);
      step(1);
      chk(count == 8'd0, "R3", int'(count), 0);
      chk(ovf_flag, "R3", int'(ovf_flag), 1);
      ovf_flag_clr = 1'b1;
      step(1);
      ovf_flag_clr = 1'b0;
      chk(!ovf_flag, "R12", int'(ovf_flag), 0);

      // R12: set wins over clear on the same edge
      wait_count(255);
      ovf_flag_clr = 1'b1;
      step(1);
      ovf_flag_clr = 1'b0;
      chk(ovf_flag, "R12", int'(ovf_flag), 1);

      // R2: stop codes and divide ratios
      clk_sel = 3'd0;
      v = int'(count);
      step(20);
      chk(int'(count) == v, "R2", int'(count), v);
      clk_sel = 3'd2;
      changes = 0;
      v = int'(count);
      for (int i = 0; i < 80; i++) begin
         step(1);
         if (int'(count) != v) changes++;
         v = int'(count);
      end
      chk(changes == 10, "R2", changes, 10);
      clk_sel = 3'd3;
      step(300);
      clk_sel = 3'd5;
      step(3000);
      clk_sel = 3'd7;
      v = int'(count);
      step(40);
      chk(int'(count) == v, "R2", int'(count), v);

      // R6: toggle period in clear-on-match mode
      clk_sel = 3'd1;
      wave_mode = 2'd2;
      out_mode = 2'd1;
      write_cmp(4);
      measure_toggles(5, "R6");
      write_cmp(0);
      measure_toggles(1, "R6");

      // R5: compare written below the count is missed until wrap
      write_cmp(100);
      wait_count(50);
      write_cmp(20);
      step(60);
      chk(int'(count) > 20, "R5", int'(count), 21);

      // R10: immediate compare update outside PWM
      wait_count(5);
      write_cmp(10);
      seen_max = 0;
      for (int i = 0; i < 30; i++) begin
         step(1);
         if (int'(count) > seen_max) seen_max = int'(count);
      end
      chk(seen_max <= 10, "R10", seen_max, 10);

      // R13: clear and set on match
      out_mode = 2'd2;
      wait_count(10);
      step(1);
      chk(!wave_out, "R13", int'(wave_out), 0);
      out_mode = 2'd3;
      wait_count(10);
      step(1);
      chk(wave_out, "R13", int'(wave_out), 1);

      // R7: non-inverting fast PWM duty
      wave_mode = 2'd3;
      out_mode = 2'd2;
      write_cmp(64);
      wait_count(255);
      step(1);
      high_cycles(65, "R7");

      // R9: buffered compare write in PWM
      wait_count(10);
      write_cmp(30);
      wait_count(40);
      chk(wave_out, "R9", int'(wave_out), 1);
      wait_count(255);
      step(1);
      wait_count(40);
      chk(!wave_out, "R9", int'(wave_out), 0);

      // R8: inverting fast PWM duty
      out_mode = 2'd3;
      wait_count(255);
      step(1);
      high_cycles(225, "R8");

      // R11: hold mode freezes the pin
      wait_count(100);
      out_mode = 2'd0;
      held = wave_out;
      step(600);
      chk(wave_out == held, "R11", int'(wave_out), int'(held));
      wave_mode = 2'd2;
      step(300);
      chk(wave_out == held, "R11", int'(wave_out), int'(held));

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule